// File: doc/BRIEF.md
# Parallel Camera Sensor Capture Interface

This block accepts the raw pins of a parallel image sensor (pixel clock, frame sync, line sync and a 10-bit pixel bus) and turns them into a stream of tagged words in the system clock domain. All sensor pins are brought across with a synchronizer and then oversampled by the faster system clock. A pixel is taken on each rising edge of the synchronized pixel clock that passes qualification. The pixel clock must run at no more than a quarter of the system clock rate.

Two qualification modes exist. In gated mode a pixel counts only while the line sync is high. In free-running mode the line sync is ignored, and every pixel-clock rising edge inside a frame is taken. The mode input is latched only when a frame starts, so a frame never changes mode partway through. Each captured word carries a start-of-frame flag and, in gated mode, a start-of-line flag. Words queue in a small FIFO and leave through a valid/ready port. A sticky overflow flag records every word lost to a full FIFO.

Top module: `cam_capture`

## Requirements
- R1: Right after reset, `out_valid` and `ovf_flag` are both 0.
- R2: A frame opens on a rising edge of `sen_vsync` and stays open while `sen_vsync` is high. Pixel-clock rising edges while `sen_vsync` is low produce no word in either mode.
- R3: In gated mode (`mode_free` latched as 0), a word is produced for each pixel-clock rising edge while `sen_hsync` is high. Edges while `sen_hsync` is low produce no word.
- R4: In free-running mode (`mode_free` latched as 1), `sen_hsync` has no effect, and every pixel-clock rising edge inside a frame produces a word.
- R5: `out_data` carries all 10 bits present on `sen_data` at the qualifying pixel-clock rising edge, unchanged, with words in capture order. An 8-bit sensor wired to bits 7:0 with bits 9:8 tied low yields words whose bits 9:8 are 0.
- R6: `out_sof` is 1 on the first word captured after each `sen_vsync` rising edge and 0 on every other word.
- R7: In gated mode, `out_sol` is 1 on the first word captured after each `sen_hsync` rising edge and 0 on every other word. In free-running mode, `out_sol` is always 0.
- R8: `mode_free` is sampled only at a `sen_vsync` rising edge. A change during a frame has no effect until the next frame.
- R9: The FIFO holds 8 words. While `out_valid` is 1 and `out_ready` is 0, the word on `out_data`, `out_sof` and `out_sol` stays unchanged. A word is removed on each cycle where both are 1.
- R10: A word that arrives while the FIFO holds 8 words and none is removed that cycle is dropped, and `ovf_flag` is set. `ovf_flag` stays set until a one-cycle pulse on `ovf_clear` clears it. The 8 words already queued are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_free | input | 1 | 0 = gated by line sync, 1 = free-running; latched at frame start |
| sen_pclk | input | 1 | Sensor pixel clock (asynchronous) |
| sen_vsync | input | 1 | Sensor frame sync, active high |
| sen_hsync | input | 1 | Sensor line sync, active high |
| sen_data | input | 10 | Sensor pixel bus |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 10 | Captured pixel value |
| out_sof | output | 1 | Word is the first of its frame |
| out_sol | output | 1 | Word is the first of its line (gated mode) |
| ovf_flag | output | 1 | Sticky FIFO overflow indicator |
| ovf_clear | input | 1 | Pulse to clear `ovf_flag` |

## Verification
The bench builds the block with its default values: an 8-entry FIFO and a two-stage synchronizer. The pixel clock runs at one eighth of the system clock. With only 8 entries, the exact boundary between the last kept word and the first dropped one is reached in a single short frame. The bench sweeps both modes over every combination of 1 to 3 lines and 1 to 4 pixels per line. Blanking edges, line-sync activity in free-running mode, mid-frame mode changes and a stalling consumer are woven into that sweep.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

    localparam int PIX_W = 10;

    typedef enum logic {
        MODE_GATED = 1'b0,
        MODE_FREE  = 1'b1
    } cap_mode_e;

    // sensor pins after synchronization
    typedef struct packed {
        logic             vsync;
        logic             hsync;
        logic             pclk;
        logic [PIX_W-1:0] data;
    } sen_bus_t;

    // one captured word with its markers
    typedef struct packed {
        logic             sof;
        logic             sol;
        logic [PIX_W-1:0] pix;
    } cap_word_t;

    function automatic logic rose(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

    function automatic logic [31:0] ptr_next(input logic [31:0] p, input int unsigned depth);
        return (p == depth - 1) ? 32'd0 : p + 32'd1;
    endfunction

endpackage

// File: rtl/cam_sync.sv
module cam_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cam_qualify.sv
module cam_qualify
    import cam_cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sen_bus_t  bus_s,
    input  cap_mode_e mode_req,
    output logic      cap_valid,
    output cap_word_t cap_word,
    output cap_mode_e active_mode
);
    sen_bus_t  prev;
    logic      sof_pend, sol_pend;
    logic      vs_rise, hs_rise, pclk_rise;
    cap_mode_e eff_mode;
    logic      take;
    logic      sof_now, sol_now;

    assign vs_rise   = rose(bus_s.vsync, prev.vsync);
    assign hs_rise   = rose(bus_s.hsync, prev.hsync);
    assign pclk_rise = rose(bus_s.pclk,  prev.pclk);

    // a frame starting this very cycle already runs in the requested mode
    assign eff_mode = vs_rise ? mode_req : active_mode;

    always_comb begin
        take = pclk_rise & bus_s.vsync;
        if (eff_mode == MODE_GATED) take = take & bus_s.hsync;
    end

    assign sof_now = sof_pend | vs_rise;
    assign sol_now = (sol_pend | hs_rise) & (eff_mode == MODE_GATED);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev        <= '0;
            active_mode <= MODE_GATED;
            sof_pend    <= 1'b0;
            sol_pend    <= 1'b0;
            cap_valid   <= 1'b0;
            cap_word    <= '0;
        end else begin
            prev        <= bus_s;
            active_mode <= eff_mode;
            cap_valid   <= take;
            if (take) begin
                cap_word.sof <= sof_now;
                cap_word.sol <= sol_now;
                cap_word.pix <= bus_s.data;
            end
            sof_pend <= take ? 1'b0 : (sof_pend | vs_rise);
            sol_pend <= take ? 1'b0 : (sol_pend | hs_rise);
        end
    end

    p_no_cap_outside_r2: assert property (@(posedge clk) disable iff (rst)
        (pclk_rise && !bus_s.vsync) |=> !cap_valid);

    p_gated_hsync_r3: assert property (@(posedge clk) disable iff (rst)
        (pclk_rise && !bus_s.hsync && !vs_rise && active_mode == MODE_GATED) |=> !cap_valid);

    p_sol_free_r7: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && active_mode == MODE_FREE) |-> !cap_word.sol);

    p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !vs_rise |=> $stable(active_mode));
endmodule

// File: rtl/cam_fifo.sv
module cam_fifo
    import cam_cap_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  cap_word_t wdata,
    output logic      rvalid,
    input  logic      rready,
    output cap_word_t rdata,
    output logic      ovf,
    input  logic      ovf_clr
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    cap_word_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, do_pop, do_push, drop;

    assign full    = (count == CNT_W'(DEPTH));
    assign rvalid  = (count != '0);
    assign rdata   = mem[rd_ptr];
    assign do_pop  = rvalid & rready;
    assign do_push = push & (~full | do_pop);
    assign drop    = push & full & ~do_pop;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= PTR_W'(ptr_next(32'(wr_ptr), DEPTH));
            if (do_pop)  rd_ptr <= PTR_W'(ptr_next(32'(rd_ptr), DEPTH));
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/cam_capture.sv
module cam_capture
    import cam_cap_pkg::*;
#(
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_free,
    input  logic             sen_pclk,
    input  logic             sen_vsync,
    input  logic             sen_hsync,
    input  logic [PIX_W-1:0] sen_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             out_sof,
    output logic             out_sol,
    output logic             ovf_flag,
    input  logic             ovf_clear
);
    localparam int BUS_W = $bits(sen_bus_t);

    sen_bus_t   raw_bus, bus_s;
    logic [BUS_W-1:0] bus_q;
    cap_mode_e  mode_req, active_mode;
    logic       cap_valid;
    cap_word_t  cap_word, head;

    assign raw_bus = '{vsync: sen_vsync, hsync: sen_hsync, pclk: sen_pclk, data: sen_data};
    assign mode_req = mode_free ? MODE_FREE : MODE_GATED;

    cam_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bus),
        .q   (bus_q)
    );
    assign bus_s = sen_bus_t'(bus_q);

    cam_qualify u_qual (
        .clk         (clk),
        .rst         (rst),
        .bus_s       (bus_s),
        .mode_req    (mode_req),
        .cap_valid   (cap_valid),
        .cap_word    (cap_word),
        .active_mode (active_mode)
    );

    cam_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (cap_valid),
        .wdata   (cap_word),
        .rvalid  (out_valid),
        .rready  (out_ready),
        .rdata   (head),
        .ovf     (ovf_flag),
        .ovf_clr (ovf_clear)
    );

    assign out_data = head.pix;
    assign out_sof  = head.sof;
    assign out_sol  = head.sol;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !ovf_flag));
endmodule

// File: tb/cam_capture_test.sv
module cam_capture_test;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_free = 1'b0;
    logic       sen_pclk = 1'b0, sen_vsync = 1'b0, sen_hsync = 1'b0;
    logic [9:0] sen_data = '0;
    logic       out_ready = 1'b1;
    logic       ovf_clear = 1'b0;
    logic       out_valid, out_sof, out_sol, ovf_flag;
    logic [9:0] out_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state, derived from the requirements
    bit m_mode = 0, m_sof = 0, m_sol = 0;
    bit hold_low = 0, toggle_en = 0;
    logic [11:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    cam_capture uut (
        .clk(clk), .rst(rst), .mode_free(mode_free),
        .sen_pclk(sen_pclk), .sen_vsync(sen_vsync), .sen_hsync(sen_hsync), .sen_data(sen_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_sol(out_sol), .ovf_flag(ovf_flag), .ovf_clear(ovf_clear)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ready is driven only here, between edges
    always @(posedge clk) begin
        #2;
        if (hold_low)       out_ready = 1'b0;
        else if (toggle_en) out_ready = ~out_ready;
        else                out_ready = 1'b1;
    end

    // consumer: compare each accepted word with the model
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R2 R3 R4 extra word", {out_sof, out_sol, out_data}, 0);
            end else begin
                logic [11:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_sof, out_sol, out_data} === e, t, {out_sof, out_sol, out_data}, e);
            end
        end
    end

    task automatic expect_word(input logic [9:0] d);
        logic [11:0] w;
        w = {m_sof, m_sol && !m_mode, d};
        m_sof = 0;
        m_sol = 0;
        if (hold_low && exp_q.size() >= DEPTH) return;
        exp_q.push_back(w);
        tag_q.push_back(m_mode ? "R4 R5 R6 R7" : "R3 R5 R6 R7");
    endtask

    task automatic pix(input logic [9:0] d);
        sen_data = d;
        tick(4);
        sen_pclk = 1'b1;
        if (sen_vsync && (m_mode || sen_hsync)) expect_word(d);
        tick(4);
        sen_pclk = 1'b0;
    endtask

    task automatic vs_up();
        sen_vsync = 1'b1; m_sof = 1; m_mode = mode_free; tick(4);
    endtask
    task automatic vs_down();
        sen_vsync = 1'b0; tick(4);
    endtask
    task automatic hs_up();
        sen_hsync = 1'b1; m_sol = 1; tick(4);
    endtask
    task automatic hs_down();
        sen_hsync = 1'b0; tick(4);
    endtask

    task automatic drain(input string req);
        tick(40);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(ovf_flag == 1'b0, "R1", ovf_flag, 0);

        // pixel clock outside any frame: nothing captured in either mode
        for (int m = 0; m < 2; m++) begin
            mode_free = m[0]; m_mode = m[0];
            sen_hsync = 1'b1;
            for (int i = 0; i < 3; i++) pix(10'(i + 5));
            sen_hsync = 1'b0;
            for (int i = 0; i < 2; i++) pix(10'(i + 9));
            drain("R2");
        end

        // sweep of frame shapes in both modes
        for (int m = 0; m < 2; m++) begin
            mode_free = m[0];
            toggle_en = m[0];
            tick(4);
            for (int nl = 1; nl <= 3; nl++) begin
                for (int np = 1; np <= 4; np++) begin
                    vs_up();
                    for (int l = 0; l < nl; l++) begin
                        pix(10'((m * 301 + nl * 97 + l * 13) & 10'h3ff));
                        hs_up();
                        for (int p = 0; p < np; p++)
                            pix(10'((m * 211 + nl * 53 + np * 29 + l * 7 + p * 3) & 10'h3ff));
                        hs_down();
                    end
                    pix(10'h155);
                    vs_down();
                end
            end
            drain(m ? "R4" : "R3");
        end
        toggle_en = 0;

        // extreme values, 10-bit and 8-bit sensor
        mode_free = 1'b0; tick(4);
        vs_up(); hs_up();
        pix(10'h3ff); pix(10'h000); pix(10'h2aa); pix(10'h0ff); pix(10'h0a5);
        hs_down(); vs_down();
        drain("R5");

        // mode change mid-frame is deferred to the next frame
        mode_free = 1'b0; tick(4);
        vs_up();
        hs_up(); pix(10'h011); pix(10'h012); hs_down();
        mode_free = 1'b1; tick(6);
        pix(10'h013); pix(10'h014);
        hs_up(); pix(10'h015); hs_down();
        vs_down();
        drain("R8");
        vs_up();
        pix(10'h021); pix(10'h022);
        hs_up(); pix(10'h023); hs_down();
        mode_free = 1'b0; tick(6);
        pix(10'h024);
        vs_down();
        drain("R8");
        vs_up();
        pix(10'h031);
        hs_up(); pix(10'h032); hs_down();
        vs_down();
        drain("R8");

        // backpressure and overflow
        mode_free = 1'b1; tick(4);
        hold_low = 1; tick(4);
        vs_up();
        for (int i = 0; i < DEPTH; i++) pix(10'(10'h100 + i));
        tick(8);
        check(ovf_flag == 1'b0, "R10", ovf_flag, 0);
        check(out_valid == 1'b1 && out_data == 10'h100 && out_sof == 1'b1, "R9",
              {out_valid, out_sof, out_data}, {2'b11, 10'h100});
        pix(10'h1f0); pix(10'h1f1);
        tick(8);
        check(ovf_flag == 1'b1, "R10", ovf_flag, 1);
        check(out_data == 10'h100, "R9", out_data, 10'h100);
        vs_down();
        hold_low = 0;
        drain("R10");
        check(ovf_flag == 1'b1, "R10", ovf_flag, 1);
        ovf_clear = 1'b1; tick(1); ovf_clear = 1'b0; tick(1);
        check(ovf_flag == 1'b0, "R10", ovf_flag, 0);
        check(out_valid == 1'b0, "R10", out_valid, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule